// File: doc/BRIEF.md
# Byte-Protocol Register Slave for a Two-Wire Bus

This block is the serial front end of a two-wire bus device that owns four 8-bit control registers. It watches raw clock and data line levels with the system clock, cleans them through a synchronizer and a majority vote, and finds start and stop conditions. It then runs the slave side of single-byte write and single-byte read transactions. The register file itself lives in neighbouring logic: this block hands out a one-cycle write strobe with the register select and data, and reads register contents back from a flat input vector.

The block answers three kinds of address. The first is its own 7-bit address, whose upper two bits are fixed and whose lower five bits come from a configuration input. The second is a broadcast address for writes only, which neighbouring logic can mask. The third is an alert-response address: on a read to it, while an alert is pending, the block sends its own address back and reports that the alert was answered. A write is held back until a stop condition arrives, so a transaction that is cut short by a repeated start changes nothing.

Top module: `smb_reg_slave`

## Requirements
- R1: The own address is {1,0,dev_addr_cfg[4:0]} (bit 6 first). It is acknowledged for both writes and reads by pulling SDA low during the ninth clock. Each such match gives a one-cycle `addr_hit` pulse.
- R2: Address 7'b1011101 with the write bit (0) is acknowledged and handled as a register write only while `mass_wr_en` is 1. With the read bit (1) it is never acknowledged.
- R3: Address 7'b0001100 with the read bit, while `alert_pending` is 1, is acknowledged. The block then returns the byte {own address, 1} MSB first and pulses `ara_done` at the ninth clock of that byte. While `alert_pending` is 0 the address is not acknowledged.
- R4: In the command byte, bits 1:0 select register 0 to 3 and bits 7:2 have no effect.
- R5: After start, address+write, command and data (each acknowledged), the data byte is committed only at the stop condition. The commit is a single-cycle `wr_stb` carrying `wr_sel` and `wr_data`.
- R6: When a repeated start comes before the stop, the pending data byte is dropped and no `wr_stb` is produced for it.
- R7: After a command byte, a repeated start and address+read, the block sends `reg_rd_vec[8*sel +: 8]` MSB first, where sel is the last command's bits 1:0. A read never produces `wr_stb`.
- R8: While `enable` is 0 the block acknowledges nothing, releases SDA and produces no strobes.
- R9: The SDA drive changes only while the filtered SCL is low. SDA is released in the low phase that follows each acknowledge or each transmitted byte.
- R10: Any other address is not acknowledged, and the transaction that follows produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 lets the block take part in bus traffic |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| dev_addr_cfg | input | 5 | Low five bits of the own address |
| mass_wr_en | input | 1 | Allows the broadcast write address |
| alert_pending | input | 1 | An alert is waiting to be answered |
| reg_rd_vec | input | 32 | Register contents, register n in bits 8n+7:8n |
| sda_drive_low | output | 1 | 1 pulls the data line low (open drain) |
| wr_stb | output | 1 | One-cycle register write commit |
| wr_sel | output | 2 | Register index of the commit |
| wr_data | output | 8 | Data of the commit |
| addr_hit | output | 1 | One-cycle pulse when the own address is acknowledged |
| ara_done | output | 1 | One-cycle pulse when the alert-response byte has been sent |

## Verification
The bench addresses the block with its own address, the broadcast address with the mask open and closed, the alert-response address with and without a pending alert, and an unrelated address. Comparing the acknowledge bit and the strobes across these cases separates the four address classes. Command bytes with their upper bits set show that only the low two bits select a register. One write is interrupted by a repeated start and then followed by a complete write: this separates commit-at-stop from commit-at-acknowledge, because only the second data byte may appear. A transaction sent with `enable` low shows that the block ignores the bus.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

  localparam logic [6:0] BCAST_WR_ADDR = 7'b1011101;
  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } eng_state_t;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_OWN,
    HIT_BCAST,
    HIT_ALERT
  } hit_kind_t;

  function automatic logic [6:0] own_address(input logic [4:0] cfg);
    return {2'b10, cfg};
  endfunction

  function automatic logic [7:0] alert_reply(input logic [4:0] cfg);
    return {own_address(cfg), 1'b1};
  endfunction

  function automatic hit_kind_t classify_addr(input logic [6:0] addr7,
                                              input logic rd,
                                              input logic [4:0] cfg,
                                              input logic bcast_ok,
                                              input logic alert);
    if (addr7 == own_address(cfg)) return HIT_OWN;
    if (addr7 == BCAST_WR_ADDR && !rd && bcast_ok) return HIT_BCAST;
    if (addr7 == ALERT_RESP_ADDR && rd && alert) return HIT_ALERT;
    return HIT_NONE;
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(VOTE_TAPS + 1);
  localparam int THRESH = (VOTE_TAPS + 1) / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;
  logic [CW-1:0]          ones;

  always_comb ones = CW'($countones(hist_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      hist_q   <= '1;
      line_out <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], line_in};
      hist_q   <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_out <= (ones >= CW'(THRESH));
    end
  end
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int NUM_REGS = 4,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic [4:0]             dev_addr_cfg,
  input  logic                   mass_wr_en,
  input  logic                   alert_pending,
  input  logic [NUM_REGS*DW-1:0] reg_rd_vec,
  output logic                   sda_drive_low,
  output logic                   wr_stb,
  output logic [$clog2(NUM_REGS)-1:0] wr_sel,
  output logic [DW-1:0]          wr_data,
  output logic                   addr_hit,
  output logic                   ara_done
);
  import smb_slave_pkg::*;

  localparam int SEL_W = $clog2(NUM_REGS);
  localparam int FRAME_BITS = 8;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  // line conditioning, one filter per wire
  logic [1:0] raw_lines, clean_lines;
  logic scl_f, sda_f;
  assign raw_lines = {scl_in, sda_in};

  for (genvar gi = 0; gi < 2; gi++) begin : g_filt
    smb_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS(VOTE_TAPS)
    ) u_filt (
      .clk(clk),
      .rst_n(rst_n),
      .line_in(raw_lines[gi]),
      .line_out(clean_lines[gi])
    );
  end

  assign scl_f = clean_lines[1];
  assign sda_f = clean_lines[0];

  logic scl_rise, scl_fall, start_det, stop_det;

  smb_cond_detect u_cond (
    .clk(clk),
    .rst_n(rst_n),
    .scl_f(scl_f),
    .sda_f(sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_det(start_det),
    .stop_det(stop_det)
  );

  // protocol engine
  eng_state_t          state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [7:0]          shreg;
  logic [7:0]          tx_sh;
  logic [SEL_W-1:0]    cmd_ptr;
  logic                wr_pend;
  logic [SEL_W-1:0]    pend_sel;
  logic [DW-1:0]       pend_data;
  logic                is_read, is_alert;
  logic                frame_done;
  hit_kind_t           hit_kind;
  logic [DW-1:0]       rd_byte;
  logic [7:0]          tx_first;

  assign frame_done = (bit_cnt == CNT_W'(FRAME_BITS));
  assign hit_kind   = classify_addr(shreg[7:1], shreg[0], dev_addr_cfg,
                                    mass_wr_en, alert_pending);
  assign rd_byte    = reg_rd_vec[cmd_ptr*DW +: DW];
  assign tx_first   = is_alert ? alert_reply(dev_addr_cfg) : 8'(rd_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      tx_sh         <= '0;
      cmd_ptr       <= '0;
      wr_pend       <= 1'b0;
      pend_sel      <= '0;
      pend_data     <= '0;
      is_read       <= 1'b0;
      is_alert      <= 1'b0;
      sda_drive_low <= 1'b0;
      wr_stb        <= 1'b0;
      wr_sel        <= '0;
      wr_data       <= '0;
      addr_hit      <= 1'b0;
      ara_done      <= 1'b0;
    end else if (!enable) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      cmd_ptr       <= '0;
      wr_pend       <= 1'b0;
      is_read       <= 1'b0;
      is_alert      <= 1'b0;
      sda_drive_low <= 1'b0;
      wr_stb        <= 1'b0;
      addr_hit      <= 1'b0;
      ara_done      <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      addr_hit <= 1'b0;
      ara_done <= 1'b0;
      if (start_det) begin
        state         <= ST_ADDR;
        bit_cnt       <= '0;
        wr_pend       <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
        wr_pend       <= 1'b0;
        if (wr_pend) begin
          wr_stb  <= 1'b1;
          wr_sel  <= pend_sel;
          wr_data <= pend_data;
        end
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (scl_rise && !frame_done) begin
              shreg   <= {shreg[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && frame_done) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (hit_kind == HIT_NONE) begin
                  state <= ST_SKIP;
                end else begin
                  sda_drive_low <= 1'b1;
                  state         <= ST_ADDR_ACK;
                  is_read       <= shreg[0];
                  is_alert      <= (hit_kind == HIT_ALERT);
                  addr_hit      <= (hit_kind == HIT_OWN);
                end
              end else if (state == ST_CMD) begin
                cmd_ptr       <= shreg[SEL_W-1:0];
                sda_drive_low <= 1'b1;
                state         <= ST_CMD_ACK;
              end else begin
                pend_data     <= DW'(shreg);
                pend_sel      <= cmd_ptr;
                wr_pend       <= 1'b1;
                sda_drive_low <= 1'b1;
                state         <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sh         <= tx_first;
                sda_drive_low <= ~tx_first[7];
                state         <= ST_TX;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              state         <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              state         <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (frame_done) begin
                sda_drive_low <= 1'b0;
                state         <= ST_TX_ACK;
              end else begin
                tx_sh         <= {tx_sh[6:0], 1'b0};
                sda_drive_low <= ~tx_sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ara_done <= is_alert;
              state    <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: drive only moves while the cleaned clock is low
  a_r9_sda_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (sda_drive_low != $past(sda_drive_low)) |-> (!scl_f || !$past(enable)));

  // R5: a commit follows a detected stop
  a_r5_strobe_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(stop_det));

  // R8: silent while disabled
  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sda_drive_low && !wr_stb && !addr_hit && !ara_done));

  // R1: own-address hit comes with the acknowledge, after a clock fall
  a_r1_hit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> ($past(scl_fall) && sda_drive_low));

  // R3: alert answer reported at a clock rise with the line released
  a_r3_answer_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ara_done |-> ($past(scl_rise) && !sda_drive_low));

endmodule

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [4:0]  cfg = 5'b10110;
  logic        mw_en = 1'b1;
  logic        alert = 1'b0;
  logic [31:0] rd_vec = {8'hC3, 8'h96, 8'h5E, 8'h21};
  logic        drv_low, wr_stb, addr_hit, ara_done;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        sda_line;

  int n_chk = 0, n_fail = 0, hits = 0, answers = 0;
  bit finished = 0;

  typedef struct packed { logic [1:0] sel; logic [7:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~drv_low;

  smb_reg_slave u_smb_reg_slave (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_in(scl_m), .sda_in(sda_line),
    .dev_addr_cfg(cfg), .mass_wr_en(mw_en), .alert_pending(alert),
    .reg_rd_vec(rd_vec), .sda_drive_low(drv_low),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_hit(addr_hit), .ara_done(ara_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each commit
  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_hit) hits++;
      if (ara_done) answers++;
      if (wr_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R10 unexpected commit", {wr_sel, wr_data}, 0);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          chk({wr_sel, wr_data} == {it.sel, it.data}, "R5 commit contents",
              {wr_sel, wr_data}, {it.sel, it.data});
        end
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    scl_m = 1'b0; wait_q();
    sda_m = b;    wait_q();
    scl_m = 1'b1; wait_q();
    s = sda_line; wait_q();
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    repeat (20) @(negedge clk);
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack, output logic rel);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
    wait_q();
    rel = sda_line;
  endtask

  task automatic byte_in(input logic master_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~master_ack, s);
  endtask

  // driver: full write-byte transaction, pushes expected commit
  task automatic do_write(input logic [6:0] a7, input logic [7:0] cmd, input logic [7:0] data,
                          input bit exp_ack, input string tag);
    logic ack, rel;
    if (exp_ack) exp_q.push_back({cmd[1:0], data});
    bus_start();
    byte_out({a7, 1'b0}, ack, rel);
    chk(ack == exp_ack, {tag, " address ack"}, ack, exp_ack);
    if (ack) begin
      byte_out(cmd, ack, rel);
      chk(ack, {tag, " command ack"}, ack, 1);
      byte_out(data, ack, rel);
      chk(ack, {tag, " data ack"}, ack, 1);
    end
    bus_stop();
    chk(exp_q.size() == 0, {tag, " commit seen at stop"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, rel;
    logic [7:0] rb;
    int h0;
    logic [6:0] own;
    own = {2'b10, cfg};

    repeat (5) @(negedge clk);
    chk(drv_low == 1'b0 && wr_stb == 1'b0, "reset state", {drv_low, wr_stb}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 + R5 + R9: plain write to own address
    h0 = hits;
    exp_q.push_back({2'd2, 8'hA5});
    bus_start();
    byte_out({own, 1'b0}, ack, rel);
    chk(ack, "R1 own address ack", ack, 1);
    chk(rel, "R9 released after ack", rel, 1);
    byte_out(8'h02, ack, rel);
    chk(ack, "R1 command ack", ack, 1);
    byte_out(8'hA5, ack, rel);
    chk(ack && rel, "R9 data ack then release", {ack, rel}, 2'b11);
    chk(exp_q.size() == 1, "R5 no commit before stop", exp_q.size(), 1);
    bus_stop();
    chk(exp_q.size() == 0, "R5 commit at stop", exp_q.size(), 0);
    chk(hits == h0 + 1, "R1 addr_hit pulse", hits, h0 + 1);

    // R4: upper command bits ignored
    do_write(own, 8'hFD, 8'h3C, 1'b1, "R4 upper bits");

    // R6: repeated start discards, following write commits
    exp_q.push_back({2'd0, 8'h11});
    bus_start();
    byte_out({own, 1'b0}, ack, rel);
    byte_out(8'h03, ack, rel);
    byte_out(8'h77, ack, rel);
    chk(ack, "R6 interrupted data ack", ack, 1);
    bus_start();
    byte_out({own, 1'b0}, ack, rel);
    byte_out(8'h00, ack, rel);
    byte_out(8'h11, ack, rel);
    bus_stop();
    chk(exp_q.size() == 0, "R6 only second write commits", exp_q.size(), 0);

    // R7: read byte via command 0x05 -> register 1
    bus_start();
    byte_out({own, 1'b0}, ack, rel);
    byte_out(8'h05, ack, rel);
    bus_start();
    byte_out({own, 1'b1}, ack, rel);
    chk(ack, "R7 read address ack", ack, 1);
    byte_in(1'b0, rb);
    chk(rb == 8'h5E, "R7 read data", rb, 8'h5E);
    bus_stop();
    // read of register 3
    bus_start();
    byte_out({own, 1'b0}, ack, rel);
    byte_out(8'h03, ack, rel);
    bus_start();
    byte_out({own, 1'b1}, ack, rel);
    byte_in(1'b0, rb);
    chk(rb == 8'hC3, "R7 read data reg3", rb, 8'hC3);
    bus_stop();

    // R2: broadcast write, mask open and closed, read never
    mw_en = 1'b1;
    do_write(7'b1011101, 8'h00, 8'h5A, 1'b1, "R2 broadcast enabled");
    mw_en = 1'b0;
    do_write(7'b1011101, 8'h01, 8'h66, 1'b0, "R2 broadcast masked");
    mw_en = 1'b1;
    bus_start();
    byte_out({7'b1011101, 1'b1}, ack, rel);
    chk(!ack, "R2 broadcast read nack", ack, 0);
    bus_stop();

    // R3: alert response
    alert = 1'b1;
    h0 = answers;
    bus_start();
    byte_out({7'b0001100, 1'b1}, ack, rel);
    chk(ack, "R3 alert address ack", ack, 1);
    byte_in(1'b0, rb);
    chk(rb == {own, 1'b1}, "R3 alert reply byte", rb, {own, 1'b1});
    bus_stop();
    chk(answers == h0 + 1, "R3 ara_done pulse", answers, h0 + 1);
    alert = 1'b0;
    bus_start();
    byte_out({7'b0001100, 1'b1}, ack, rel);
    chk(!ack, "R3 no alert nack", ack, 0);
    bus_stop();
    chk(answers == h0 + 1, "R3 no extra answer", answers, h0 + 1);

    // R10: unrelated address
    do_write(7'b0110011, 8'h02, 8'hEE, 1'b0, "R10 foreign address");

    // R8: disabled
    enable = 1'b0;
    repeat (5) @(negedge clk);
    do_write(own, 8'h01, 8'h99, 1'b0, "R8 disabled");
    enable = 1'b1;
    repeat (10) @(negedge clk);
    do_write(own, 8'h01, 8'h42, 1'b1, "R8 re-enabled");

    repeat (20) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule